// File: doc/BRIEF.md
# Serial Command Register Slave

This block is the configuration port of a line-rate jitter-smoothing channel. A host drives a four-wire serial bus: an active-low select, a serial clock, a data-in line, and a data-out line that the pad tri-states. Each transfer is sixteen serial clocks long. It carries a header of eight bits and then a data byte. Both the header fields and the data byte are sent least significant bit first. The block holds one writable control byte and one read-only status byte. The control byte sets the clock-edge choice, the FIFO depth, the loop bandwidth, the bypass of the smoothing loop and the line rate. The status byte reports the FIFO limit alarm.

Several channels can share one bus. Each channel is strapped with a two-bit channel number, which forms the upper part of the five-bit register address. A frame that names another channel, or that sets the reserved address bit, leaves this channel untouched, and its data-out stays undriven.

The serial pins are not treated as clocks. They pass through a synchronizer clocked by the fast system clock `clk`, and the block detects their edges inside that clock domain. The serial clock must therefore run well below the system clock. `spi_sdo_en` high means the pad drives `spi_sdo`. `spi_sdo_en` low means the pad is high impedance.

Top module: `cmdif_serial_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the control byte is zero, every `cfg_*` output is 0, `cfg_rate` is 0 (DS3) and `spi_sdo_en` is 0.
- R2: Frame layout, with one bit sampled on each rising serial-clock edge:
  - bit 1 is the direction flag (0 = write, 1 = read);
  - bits 2 to 6 are address bits A0 to A4, least significant first;
  - bit 7 is A5;
  - bit 8 is A6;
  - bits 9 to 16 are data bits D0 to D7.
  A complete write to the control address replaces the control byte with D5..D0. The control byte fields are:
  - bit0 → `cfg_edge_sel`
  - bit1 → `cfg_fifo_deep`
  - bit2 → `cfg_bw_wide`
  - bit3 → `cfg_ja_disable`
  - bit4 → `cfg_e3_sel`
  - bit5 → `cfg_sts1_sel`
  D7 and D6 are dropped.
- R3: A read of the control address returns the control byte, with bits 7:6 as zero. D0 appears on `spi_sdo` after the falling serial-clock edge that follows rising edge 8. Each later falling edge presents the next bit, up to D7.
- R4: The status address reads as `{7'b0, fifo_limit}`.
- R5: `spi_sdo_en` is 1 only in a matching read, from the falling edge after rising edge 8 until the falling edge after rising edge 16. It also drops once the select is seen high.
- R6: The control address is `{chan_addr, 2'b11, 1'b0}` and the status address is `{chan_addr, 2'b11, 1'b1}`, written as A4..A0. For example, strap 10 gives 0x16 and 0x17. A frame that addresses any other value leaves the registers unchanged and never drives `spi_sdo_en`.
- R7: A frame with A5 = 1 is ignored in the same way as in R6.
- R8: A write to the status address changes no register.
- R9: A write frame whose select rises before rising edge 16 changes no register.
- R10: `cfg_rate` decodes as follows:
  - 1 (E3) when bit4 = 1, whatever bit5 holds;
  - 2 (STS-1) when bit4 = 0 and bit5 = 1;
  - 0 (DS3) otherwise.
  The value 3 never appears.
- R11: The value of A6 has no effect on a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_addr | input | 2 | Strapped channel number |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_en | output | 1 | Pad drive enable for spi_sdo (0 = high impedance) |
| fifo_limit | input | 1 | FIFO limit alarm, reported in status bit0 |
| cfg_edge_sel | output | 1 | Control bit0: clock edge choice |
| cfg_fifo_deep | output | 1 | Control bit1: deep FIFO |
| cfg_bw_wide | output | 1 | Control bit2: wide loop bandwidth |
| cfg_ja_disable | output | 1 | Control bit3: bypass smoothing loop |
| cfg_e3_sel | output | 1 | Control bit4: E3 select |
| cfg_sts1_sel | output | 1 | Control bit5: STS-1 select |
| cfg_rate | output | 2 | Decoded line rate: 0 DS3, 1 E3, 2 STS-1 |

## Verification
The bench builds the block with the default two-stage synchronizer and straps the channel to 10, so the registers sit at 0x16 and 0x17. With that strap, frames aimed at 0x06 and 0x0E are neighbours on the same bus that must be ignored. A half serial period of twelve system clocks leaves room for the synchronizer delay before each sample point. A behavioural model of the control byte is compared with the `cfg_*` pins on every idle clock. Reads, truncated frames and the reserved address bits are checked at the pins.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int CHAN_W    = 2;
  localparam int CTRL_W    = 6;
  localparam int HDR_LEN   = 8;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  localparam int CB_EDGE = 0;
  localparam int CB_FIFO = 1;
  localparam int CB_BW   = 2;
  localparam int CB_DIS  = 3;
  localparam int CB_E3   = 4;
  localparam int CB_STS1 = 5;

  localparam logic [1:0] PAGE_CODE = 2'b11;

  typedef enum logic [1:0] {
    RATE_DS3  = 2'd0,
    RATE_E3   = 2'd1,
    RATE_STS1 = 2'd2
  } rate_e;
endpackage

// File: rtl/cmdif_sync_edge.sv
module cmdif_sync_edge
  import cmdif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_in,
  input  logic sclk_in,
  input  logic sdi_in,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b001;

  logic [NSIG-1:0] pins;
  logic [NSIG-1:0] synced;
  logic            sclk_prev;

  assign pins = {sdi_in, sclk_in, cs_n_in};

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {SYNC_STAGES{RST_VAL[g]}};
      else if (SYNC_STAGES == 1) chain_q <= pins[g];
      else chain_q <= {chain_q[SYNC_STAGES-2:0], pins[g]};
    end
    assign synced[g] = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[1];
  end

  assign cs_act    = ~synced[0];
  assign sclk_rise = synced[1] & ~sclk_prev;
  assign sclk_fall = ~synced[1] & sclk_prev;
  assign sdi_s     = synced[2];
endmodule

// File: rtl/cmdif_frame_engine.sv
module cmdif_frame_engine
  import cmdif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] chan_addr,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              reg_sel,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam logic [CNT_W-1:0] C_ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_A5        = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] C_HDR       = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] C_LAST      = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_END       = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0]  cnt_q;
  logic              rw_q;
  logic              a5_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wsh_q;
  logic [DATA_W-1:0] rsh_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              commit_q;
  logic              sdo_q;
  logic              sdo_en_q;
  logic              hit;

  assign hit = (addr_q[ADDR_W-1 -: CHAN_W] == chan_addr) &&
               (addr_q[2:1] == PAGE_CODE) && !a5_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rw_q      <= 1'b0;
      a5_q      <= 1'b0;
      addr_q    <= '0;
      wsh_q     <= '0;
      rsh_q     <= '0;
      wr_data_q <= '0;
      commit_q  <= 1'b0;
      sdo_q     <= 1'b0;
      sdo_en_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (!cs_act) begin
        cnt_q    <= '0;
        rw_q     <= 1'b0;
        a5_q     <= 1'b0;
        addr_q   <= '0;
        sdo_q    <= 1'b0;
        sdo_en_q <= 1'b0;
      end else begin
        if (sclk_rise && (cnt_q < C_END)) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0)              rw_q   <= sdi_s;
          else if (cnt_q <= C_ADDR_LAST) addr_q <= {sdi_s, addr_q[ADDR_W-1:1]};
          else if (cnt_q == C_A5)        a5_q   <= sdi_s;
          else if (cnt_q >= C_HDR)       wsh_q  <= {sdi_s, wsh_q[DATA_W-1:1]};
          if ((cnt_q == C_LAST) && !rw_q && hit && !addr_q[0]) begin
            commit_q  <= 1'b1;
            wr_data_q <= {sdi_s, wsh_q[DATA_W-1:1]};
          end
        end
        if (sclk_fall) begin
          if ((cnt_q == C_HDR) && rw_q && hit) begin
            sdo_en_q <= 1'b1;
            sdo_q    <= rd_data[0];
            rsh_q    <= rd_data >> 1;
          end else if (cnt_q == C_END) begin
            sdo_en_q <= 1'b0;
            sdo_q    <= 1'b0;
          end else if (sdo_en_q) begin
            sdo_q <= rsh_q[0];
            rsh_q <= rsh_q >> 1;
          end
        end
      end
    end
  end

  assign reg_sel   = addr_q[0];
  assign wr_commit = commit_q;
  assign wr_data   = wr_data_q;
  assign sdo       = sdo_q;
  assign sdo_en    = sdo_en_q;
endmodule

// File: rtl/cmdif_reg_bank.sv
module cmdif_reg_bank
  import cmdif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              reg_sel,
  input  logic              fifo_limit,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTRL_W-1:0] ctrl_bits,
  output rate_e             rate
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] ctrl_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (wr_commit) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign status_byte = {{(DATA_W-1){1'b0}}, fifo_limit};
  assign ctrl_byte   = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  assign rd_data     = reg_sel ? status_byte : ctrl_byte;
  assign ctrl_bits   = ctrl_q;

  always_comb begin
    if (ctrl_q[CB_E3])        rate = RATE_E3;
    else if (ctrl_q[CB_STS1]) rate = RATE_STS1;
    else                      rate = RATE_DS3;
  end
endmodule

// File: rtl/cmdif_serial_regs.sv
module cmdif_serial_regs
  import cmdif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] chan_addr,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_en,
  input  logic              fifo_limit,
  output logic              cfg_edge_sel,
  output logic              cfg_fifo_deep,
  output logic              cfg_bw_wide,
  output logic              cfg_ja_disable,
  output logic              cfg_e3_sel,
  output logic              cfg_sts1_sel,
  output logic [1:0]        cfg_rate
);
  logic              cs_act;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              sdi_s;
  logic              reg_sel;
  logic              wr_commit;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [CTRL_W-1:0] ctrl_bits;
  rate_e             rate;

  cmdif_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_in(spi_cs_n), .sclk_in(spi_sclk), .sdi_in(spi_sdi),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
  );

  cmdif_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n), .chan_addr(chan_addr),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .rd_data(rd_data), .reg_sel(reg_sel), .wr_commit(wr_commit), .wr_data(wr_data),
    .sdo(spi_sdo), .sdo_en(spi_sdo_en)
  );

  cmdif_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_data(wr_data),
    .reg_sel(reg_sel), .fifo_limit(fifo_limit), .rd_data(rd_data),
    .ctrl_bits(ctrl_bits), .rate(rate)
  );

  assign cfg_edge_sel   = ctrl_bits[CB_EDGE];
  assign cfg_fifo_deep  = ctrl_bits[CB_FIFO];
  assign cfg_bw_wide    = ctrl_bits[CB_BW];
  assign cfg_ja_disable = ctrl_bits[CB_DIS];
  assign cfg_e3_sel     = ctrl_bits[CB_E3];
  assign cfg_sts1_sel   = ctrl_bits[CB_STS1];
  assign cfg_rate       = rate;
endmodule

// File: rtl/cmdif_serial_regs_chk.sv
module cmdif_serial_regs_chk
  import cmdif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sclk_fall,
  input logic              sdo_en,
  input logic              wr_commit,
  input logic              reg_sel,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic [1:0]        rate
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_bits == '0));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_bits));

  assert_sdo_start_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> $past(sclk_fall));

  assert_sdo_off_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !sdo_en);

  assert_no_status_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !reg_sel);

  assert_rate_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rate != 2'b11);
endmodule

bind cmdif_serial_regs cmdif_serial_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .sdo_en(spi_sdo_en), .wr_commit(wr_commit), .reg_sel(reg_sel),
  .ctrl_bits(ctrl_bits), .rate(cfg_rate)
);

// File: tb/cmdif_serial_regs_tb_top.sv
module cmdif_serial_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam logic [1:0] CHAN = 2'b10;
  localparam logic [4:0] A_CTRL = {CHAN, 2'b11, 1'b0};
  localparam logic [4:0] A_STAT = {CHAN, 2'b11, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, flim = 1'b0;
  logic sdo, sdo_en;
  logic e_sel, f_deep, bw, dis, e3, sts1;
  logic [1:0] rate;

  int tests = 0, fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  bit [5:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdif_serial_regs dut_i (
    .clk(clk), .rst_n(rst_n), .chan_addr(CHAN),
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .fifo_limit(flim),
    .cfg_edge_sel(e_sel), .cfg_fifo_deep(f_deep), .cfg_bw_wide(bw),
    .cfg_ja_disable(dis), .cfg_e3_sel(e3), .cfg_sts1_sel(sts1), .cfg_rate(rate)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_rate(input bit [5:0] m);
    if (m[4]) return 1;
    if (m[5]) return 2;
    return 0;
  endfunction

  // Behavioural model compared on every idle clock (R2, R10)
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2 cfg pins", int'({sts1, e3, dis, bw, f_deep, e_sel}), int'(model));
      chk("R10 rate", int'(rate), model_rate(model));
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input bit rw, input bit [4:0] addr, input bit a5, input bit a6,
                      input bit [7:0] wdat, input int nclk,
                      output bit [7:0] rdat, output int en_cnt, output int en_bad);
    bit [15:0] frame;
    frame  = {wdat, a6, a5, addr, rw};
    rdat   = '0;
    en_cnt = 0;
    en_bad = 0;
    cmp_en = 1'b0;
    wait_clks(2);
    cs_n = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      sdi  = frame[i];
      wait_clks(HALF - 4);
      if (sdo_en) begin
        if (i >= 8) begin
          en_cnt++;
          rdat[i-8] = sdo;
        end else en_bad++;
      end
      wait_clks(4);
      sclk = 1'b1;
      wait_clks(HALF);
    end
    sclk = 1'b0;
    wait_clks(HALF);
    if (nclk == 16 && sdo_en) en_bad++;
    cs_n = 1'b1;
    wait_clks(HALF);
    if (sdo_en) en_bad++;
    if (!rw && !a5 && addr == A_CTRL && nclk >= 16) model = wdat[5:0];
    wait_clks(2);
    cmp_en = 1'b1;
  endtask

  task automatic do_read(input string req, input bit [4:0] addr, input bit a5,
                         input bit drive, input bit [7:0] exp);
    bit [7:0] rd;
    int ec, eb;
    xfer(1'b1, addr, a5, 1'b0, 8'h00, 16, rd, ec, eb);
    chk({req, " drive slots"}, ec, drive ? 8 : 0);
    chk({req, " R5 drive outside data phase"}, eb, 0);
    if (drive) chk({req, " data"}, rd, exp);
  endtask

  task automatic do_write(input bit [4:0] addr, input bit a5, input bit a6,
                          input bit [7:0] d, input int nclk);
    bit [7:0] rd;
    int ec, eb;
    xfer(1'b0, addr, a5, a6, d, nclk, rd, ec, eb);
    chk("R5 no drive in write", ec + eb, 0);
  endtask

  initial begin
    wait_clks(3);
    chk("R1 cfg in reset", int'({sts1, e3, dis, bw, f_deep, e_sel}), 0);
    chk("R1 sdo_en in reset", int'(sdo_en), 0);
    rst_n = 1'b1;
    wait_clks(4);
    chk("R1 rate after reset", int'(rate), 0);
    chk("R1 cfg after reset", int'({sts1, e3, dis, bw, f_deep, e_sel}), 0);
    cmp_en = 1'b1;

    // R2 / R3: write then read back, fields checked by the model
    do_write(A_CTRL, 1'b0, 1'b0, 8'h2A, 16);
    chk("R2 bw_wide bit2", int'(bw), 0);
    chk("R2 fifo_deep bit1", int'(f_deep), 1);
    do_read("R3 ctrl 0x2A", A_CTRL, 1'b0, 1'b1, 8'h2A);
    do_write(A_CTRL, 1'b0, 1'b0, 8'hFF, 16);
    do_read("R2 R3 ctrl upper bits zero", A_CTRL, 1'b0, 1'b1, 8'h3F);
    do_write(A_CTRL, 1'b0, 1'b0, 8'h05, 16);
    do_read("R3 ctrl 0x05", A_CTRL, 1'b0, 1'b1, 8'h05);

    // R4: status reflects alarm
    flim = 1'b1;
    do_read("R4 status alarm set", A_STAT, 1'b0, 1'b1, 8'h01);
    flim = 1'b0;
    do_read("R4 status alarm clear", A_STAT, 1'b0, 1'b1, 8'h00);

    // R6: other channels on the bus
    do_write(5'h06, 1'b0, 1'b0, 8'h3C, 16);
    do_write(5'h0E, 1'b0, 1'b0, 8'h3C, 16);
    do_read("R6 foreign read", 5'h0F, 1'b0, 1'b0, 8'h00);
    do_read("R6 ctrl kept", A_CTRL, 1'b0, 1'b1, 8'h05);

    // R7: reserved address bit set
    do_write(A_CTRL, 1'b1, 1'b0, 8'h3C, 16);
    do_read("R7 A5 read ignored", A_CTRL, 1'b1, 1'b0, 8'h00);
    do_read("R7 ctrl kept", A_CTRL, 1'b0, 1'b1, 8'h05);

    // R8: write to status
    do_write(A_STAT, 1'b0, 1'b0, 8'h3C, 16);
    do_read("R8 ctrl kept", A_CTRL, 1'b0, 1'b1, 8'h05);

    // R9: truncated write
    do_write(A_CTRL, 1'b0, 1'b0, 8'h3C, 15);
    do_write(A_CTRL, 1'b0, 1'b0, 8'h3C, 10);
    do_read("R9 ctrl kept", A_CTRL, 1'b0, 1'b1, 8'h05);

    // R11: A6 is don't-care
    do_write(A_CTRL, 1'b0, 1'b1, 8'h09, 16);
    do_read("R11 write with A6 set", A_CTRL, 1'b0, 1'b1, 8'h09);

    // R10: rate decoding
    do_write(A_CTRL, 1'b0, 1'b0, 8'h10, 16);
    chk("R10 E3", int'(rate), 1);
    do_write(A_CTRL, 1'b0, 1'b0, 8'h30, 16);
    chk("R10 E3 over STS-1", int'(rate), 1);
    do_write(A_CTRL, 1'b0, 1'b0, 8'h20, 16);
    chk("R10 STS-1", int'(rate), 2);
    do_write(A_CTRL, 1'b0, 1'b0, 8'h00, 16);
    chk("R10 DS3", int'(rate), 0);

    cmp_en = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule